// File: doc/BRIEF.md
# Programmable OR Trigger Combiner

The block reduces a wide vector of single-bit trigger terms to a small set of output channels. Each channel carries its own programmable mask over all trigger inputs, and the channel fires when any masked-in input is high. Outputs are captured only on a level-2 cycle strobe, so downstream logic sees one stable decision per cycle. The four most recent decisions of every channel are packed into one history word, readable both as a port and through the register interface.

Masks are loaded through a simple word-wide register interface. The trigger vector is cut into 16-bit slices, and each slice has its own data register. A channel-select register chooses which channels a data write lands in, and a global program-enable bit in the control register must be set before the mask table accepts any write. With it clear the table is locked.

Top module: `or_trig_combiner`

## Requirements
- R1: After reset the channel outputs, the history word, the control register, the channel-select register and every mask entry are all 0.
- R2: On a clock edge with `l2_strobe` high, `chan_out[c]` becomes the OR over all inputs `i` of `trig_in[i] AND mask[c][i]`; with no input masked in the channel gives 0.
- R3: A write to data register address 16+k (k = 0..7) loads `reg_wdata` into mask bits 16k+15..16k of every selected channel, with `reg_wdata` bit j landing on mask bit 16k+j.
- R4: Mask writes take effect only while control register (address 0) bit 3 is 1; while it is 0 every data-register write leaves the whole mask table unchanged.
- R5: The channel-select register (address 8) holds one bit per channel in bits 3:0, bit c selecting channel c; any number of bits may be set, and unselected channels keep their masks on a data write.
- R6: Reading data register 16+k returns slice k of the mask of the lowest-numbered selected channel, or 0 when no channel is selected.
- R7: On each strobe the history word shifts down by four bits and the new outputs enter bits 15:12, so bits 15:12, 11:8, 7:4 and 3:0 hold the newest to the oldest of the last four cycles, with channel n at bit n of its nibble; it is driven on `hist_word` and read at address 36.
- R8: Without a strobe the outputs and the history word hold their values whatever `trig_in` does.
- R9: The control register reads back bit 3 with all other bits 0; the channel-select register reads back bits 3:0 with all other bits 0; unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 128 | Trigger input vector |
| l2_strobe | input | 1 | Level-2 cycle strobe, captures outputs and shifts history |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| chan_out | output | 4 | Registered channel decisions |
| hist_word | output | 16 | History of the last four decisions per channel |

## Verification
Register writes land on the clock edge in the cycle `reg_wr` is high, and reads are combinational, so the bench drives the write at a falling edge, lets one rising edge pass, then sets the address and samples `reg_rdata` a step later in the same low phase. Outputs and history are due right after the rising edge that sees `l2_strobe`, so each strobe is held for exactly one edge and checked at the following falling edge against a bench model of the masks and history shift. The hold behaviour is checked by moving `trig_in` over several edges with the strobe low and comparing against the values captured before.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_CTRL  = 6'd0;
  localparam logic [ADDR_W-1:0] A_SEL   = 6'd8;
  localparam logic [ADDR_W-1:0] A_DATA0 = 6'd16;
  localparam logic [ADDR_W-1:0] A_MON   = 6'd36;
  localparam int PEN_BIT = 3;
endpackage

// File: rtl/oc_rst_sync.sv
module oc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/oc_regif.sv
module oc_regif
  import oc_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_SLICE = 8,
  parameter int HIST_W    = 16,
  localparam int SL_IW    = (NUM_SLICE > 1) ? $clog2(NUM_SLICE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              pen_wbit,
  input  logic [NUM_CH-1:0] sel_wdata,
  input  logic [DATA_W-1:0] rd_slice,
  input  logic [HIST_W-1:0] hist,
  output logic              prog_en,
  output logic [NUM_CH-1:0] ch_sel,
  output logic              slice_wr,
  output logic [SL_IW-1:0]  slice_idx,
  output logic [DATA_W-1:0] reg_rdata
);
  logic              pen_q, pen_d;
  logic [NUM_CH-1:0] sel_q, sel_d;
  logic [ADDR_W-1:0] data_off;
  logic              in_data;

  assign data_off  = reg_addr - A_DATA0;
  assign in_data   = (reg_addr >= A_DATA0) && (32'(data_off) < NUM_SLICE);
  assign slice_idx = data_off[SL_IW-1:0];
  assign slice_wr  = reg_wr && in_data && pen_q;

  always_comb begin
    pen_d = pen_q;
    sel_d = sel_q;
    if (reg_wr && reg_addr == A_CTRL) pen_d = pen_wbit;
    if (reg_wr && reg_addr == A_SEL)  sel_d = sel_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q <= 1'b0;
      sel_q <= '0;
    end else begin
      pen_q <= pen_d;
      sel_q <= sel_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL)      reg_rdata[PEN_BIT] = pen_q;
    else if (reg_addr == A_SEL)  reg_rdata[NUM_CH-1:0] = sel_q;
    else if (reg_addr == A_MON)  reg_rdata = DATA_W'(hist);
    else if (in_data)            reg_rdata = rd_slice;
  end

  assign prog_en = pen_q;
  assign ch_sel  = sel_q;
endmodule

// File: rtl/oc_mask_bank.sv
module oc_mask_bank
  import oc_pkg::*;
#(
  parameter int NUM_IN    = 128,
  parameter int NUM_CH    = 4,
  localparam int NUM_SLICE = NUM_IN / DATA_W,
  localparam int SL_IW    = (NUM_SLICE > 1) ? $clog2(NUM_SLICE) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [NUM_CH-1:0]        ch_sel,
  input  logic [SL_IW-1:0]         slice_idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rd_slice,
  output logic [NUM_CH*NUM_IN-1:0] mask_flat
);
  logic [DATA_W-1:0] slc_q [NUM_CH][NUM_SLICE];
  logic [DATA_W-1:0] slc_d [NUM_CH][NUM_SLICE];

  always_comb begin
    slc_d = slc_q;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int s = 0; s < NUM_SLICE; s++) begin
        if (wr_en && ch_sel[c] && 32'(slice_idx) == s) slc_d[c][s] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++)
        for (int s = 0; s < NUM_SLICE; s++)
          slc_q[c][s] <= '0;
    end else begin
      slc_q <= slc_d;
    end
  end

  // lowest-numbered selected channel wins the read port
  always_comb begin
    logic found;
    found    = 1'b0;
    rd_slice = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel[c] && !found) begin
        rd_slice = slc_q[c][slice_idx];
        found    = 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar s = 0; s < NUM_SLICE; s++) begin : g_sl
      assign mask_flat[c*NUM_IN + s*DATA_W +: DATA_W] = slc_q[c][s];
    end
  end
endmodule

// File: rtl/oc_or_stage.sv
module oc_or_stage #(
  parameter int NUM_IN     = 128,
  parameter int NUM_CH     = 4,
  parameter int HIST_DEPTH = 4,
  localparam int HIST_W    = NUM_CH * HIST_DEPTH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     strobe,
  input  logic [NUM_IN-1:0]        trig,
  input  logic [NUM_CH*NUM_IN-1:0] mask_flat,
  output logic [NUM_CH-1:0]        chan_out,
  output logic [HIST_W-1:0]        hist
);
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] out_q, out_d;
  logic [HIST_W-1:0] hist_q, hist_d, hist_shift;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_or
    assign hit[c] = |(trig & mask_flat[c*NUM_IN +: NUM_IN]);
  end

  if (HIST_DEPTH > 1) begin : g_deep
    assign hist_shift = {hit, hist_q[HIST_W-1:NUM_CH]};
  end else begin : g_flat
    assign hist_shift = hit;
  end

  always_comb begin
    out_d  = out_q;
    hist_d = hist_q;
    if (strobe) begin
      out_d  = hit;
      hist_d = hist_shift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      hist_q <= '0;
    end else begin
      out_q  <= out_d;
      hist_q <= hist_d;
    end
  end

  assign chan_out = out_q;
  assign hist     = hist_q;
endmodule

// File: rtl/or_trig_combiner.sv
module or_trig_combiner
  import oc_pkg::*;
#(
  parameter int NUM_IN     = 128,
  parameter int NUM_CH     = 4,
  parameter int HIST_DEPTH = 4,
  localparam int NUM_SLICE = NUM_IN / DATA_W,
  localparam int HIST_W    = NUM_CH * HIST_DEPTH,
  localparam int SL_IW     = (NUM_SLICE > 1) ? $clog2(NUM_SLICE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] trig_in,
  input  logic              l2_strobe,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] chan_out,
  output logic [HIST_W-1:0] hist_word
);
  logic                     rst_sync_n;
  logic                     prog_en;
  logic [NUM_CH-1:0]        ch_sel;
  logic                     slice_wr;
  logic [SL_IW-1:0]         slice_idx;
  logic [DATA_W-1:0]        rd_slice;
  logic [NUM_CH*NUM_IN-1:0] mask_flat;

  oc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  oc_regif #(
    .NUM_CH    (NUM_CH),
    .NUM_SLICE (NUM_SLICE),
    .HIST_W    (HIST_W)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .pen_wbit  (reg_wdata[PEN_BIT]),
    .sel_wdata (reg_wdata[NUM_CH-1:0]),
    .rd_slice  (rd_slice),
    .hist      (hist_word),
    .prog_en   (prog_en),
    .ch_sel    (ch_sel),
    .slice_wr  (slice_wr),
    .slice_idx (slice_idx),
    .reg_rdata (reg_rdata)
  );

  oc_mask_bank #(
    .NUM_IN (NUM_IN),
    .NUM_CH (NUM_CH)
  ) u_mask (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (slice_wr),
    .ch_sel    (ch_sel),
    .slice_idx (slice_idx),
    .wdata     (reg_wdata),
    .rd_slice  (rd_slice),
    .mask_flat (mask_flat)
  );

  oc_or_stage #(
    .NUM_IN     (NUM_IN),
    .NUM_CH     (NUM_CH),
    .HIST_DEPTH (HIST_DEPTH)
  ) u_or (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .strobe    (l2_strobe),
    .trig      (trig_in),
    .mask_flat (mask_flat),
    .chan_out  (chan_out),
    .hist      (hist_word)
  );
endmodule

// File: rtl/oc_checker.sv
module oc_checker
  import oc_pkg::*;
#(
  parameter int NUM_IN     = 128,
  parameter int NUM_CH     = 4,
  parameter int HIST_DEPTH = 4,
  localparam int NUM_SLICE = NUM_IN / DATA_W,
  localparam int HIST_W    = NUM_CH * HIST_DEPTH
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_IN-1:0]        trig_in,
  input logic                     l2_strobe,
  input logic                     reg_wr,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [DATA_W-1:0]        reg_rdata,
  input logic [NUM_CH-1:0]        chan_out,
  input logic [HIST_W-1:0]        hist_word,
  input logic                     prog_en,
  input logic [NUM_CH-1:0]        ch_sel,
  input logic [NUM_CH*NUM_IN-1:0] mask_flat
);
  logic in_data;
  assign in_data = (reg_addr >= A_DATA0) && (32'(reg_addr) < 32'(A_DATA0) + NUM_SLICE);

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !l2_strobe |=> ($stable(chan_out) && $stable(hist_word))); // R8

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    l2_strobe |=> hist_word[HIST_W-NUM_CH-1:0] == $past(hist_word[HIST_W-1:NUM_CH])); // R7

  AST_HIST_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    l2_strobe |=> hist_word[HIST_W-1:HIST_W-NUM_CH] == chan_out); // R7

  AST_ZERO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_strobe && trig_in == '0) |=> chan_out == '0); // R2

  AST_LOCKED_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && in_data && !prog_en) |=> $stable(mask_flat)); // R4

  AST_NOSEL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && ch_sel == '0) |-> reg_rdata == '0); // R6

  AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> (reg_rdata[DATA_W-1:PEN_BIT+1] == '0 &&
                              reg_rdata[PEN_BIT-1:0] == '0 &&
                              reg_rdata[PEN_BIT] == prog_en)); // R9
endmodule

bind or_trig_combiner oc_checker #(
  .NUM_IN     (NUM_IN),
  .NUM_CH     (NUM_CH),
  .HIST_DEPTH (HIST_DEPTH)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .trig_in   (trig_in),
  .l2_strobe (l2_strobe),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .chan_out  (chan_out),
  .hist_word (hist_word),
  .prog_en   (prog_en),
  .ch_sel    (ch_sel),
  .mask_flat (mask_flat)
);

// File: tb/or_trig_combiner_tb_top.sv
`timescale 1ns/1ps
module or_trig_combiner_tb_top;
  localparam int NI = 128;
  localparam int NC = 4;
  localparam int NS = NI / 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] trig_in = '0;
  logic          l2_strobe = 1'b0;
  logic          reg_wr = 1'b0;
  logic [5:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic [NC-1:0] chan_out;
  logic [15:0]   hist_word;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [NI-1:0] mdl [NC];
  logic [NC-1:0] exp_out;
  logic [15:0]   exp_hist;

  always #10 clk = ~clk;

  or_trig_combiner dut_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .l2_strobe(l2_strobe),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .chan_out(chan_out), .hist_word(hist_word)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [15:0] uniq(input int c, input int s);
    return 16'(c * 4099 + s * 263 + 16'h1234);
  endfunction

  function automatic bit pat(input int c, input int i);
    return ((i * 5 + c * 11) % 7) == 0;
  endfunction

  task automatic strobe(input logic [NI-1:0] v, input string tag);
    logic [15:0] r;
    @(negedge clk);
    trig_in = v; l2_strobe = 1'b1;
    @(negedge clk);
    l2_strobe = 1'b0;
    for (int c = 0; c < NC; c++) exp_out[c] = |(v & mdl[c]);
    exp_hist = {exp_out, exp_hist[15:4]};
    chk({tag, " R2 chan_out"}, 16'(chan_out), 16'(exp_out));
    chk({tag, " R7 hist_word"}, hist_word, exp_hist);
    rd(6'd36, r);
    chk({tag, " R7 monitor read"}, r, exp_hist);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [NI-1:0] v;
    for (int c = 0; c < NC; c++) mdl[c] = '0;
    exp_out = '0; exp_hist = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 chan_out", 16'(chan_out), 16'h0);
    chk("R1 hist_word", hist_word, 16'h0);
    rd(6'd0, r);  chk("R1 control", r, 16'h0);
    rd(6'd8, r);  chk("R1 select", r, 16'h0);
    wr(6'd8, 16'hF);
    for (int s = 0; s < NS; s++) begin
      rd(6'(16 + s), r); chk("R1 mask zero", r, 16'h0);
    end

    // R4 locked table
    wr(6'd16, 16'hFFFF);
    wr(6'd23, 16'hBEEF);
    for (int c = 0; c < NC; c++) begin
      wr(6'd8, 16'(1 << c));
      rd(6'd16, r); chk("R4 locked slice0", r, 16'h0);
      rd(6'd23, r); chk("R4 locked slice7", r, 16'h0);
    end

    // R9 readback masking
    wr(6'd0, 16'hFFFF); rd(6'd0, r); chk("R9 control", r, 16'h0008);
    wr(6'd8, 16'hFFFF); rd(6'd8, r); chk("R9 select", r, 16'h000F);
    rd(6'd50, r); chk("R9 unmapped", r, 16'h0);

    // R3 slice placement, one channel at a time
    for (int c = 0; c < NC; c++) begin
      wr(6'd8, 16'(1 << c));
      for (int s = 0; s < NS; s++) wr(6'(16 + s), uniq(c, s));
    end
    for (int c = 0; c < NC; c++) begin
      wr(6'd8, 16'(1 << c));
      for (int s = 0; s < NS; s++) begin
        rd(6'(16 + s), r); chk("R3 slice readback", r, uniq(c, s));
      end
    end

    // R5/R6 multi-select and priority
    wr(6'd8, 16'b0110); wr(6'd18, 16'hA5C3);
    wr(6'd8, 16'b0001); rd(6'd18, r); chk("R5 ch0 untouched", r, uniq(0, 2));
    wr(6'd8, 16'b0010); rd(6'd18, r); chk("R5 ch1 written", r, 16'hA5C3);
    wr(6'd8, 16'b0100); rd(6'd18, r); chk("R5 ch2 written", r, 16'hA5C3);
    wr(6'd8, 16'b1000); rd(6'd18, r); chk("R5 ch3 untouched", r, uniq(3, 2));
    wr(6'd8, 16'b1010); rd(6'd17, r); chk("R6 lowest ch1", r, uniq(1, 1));
    wr(6'd8, 16'b1100); rd(6'd18, r); chk("R6 lowest ch2", r, 16'hA5C3);
    wr(6'd8, 16'b0000); rd(6'd18, r); chk("R6 none selected", r, 16'h0);

    // R4 lock after programming
    wr(6'd0, 16'h0); wr(6'd8, 16'hF); wr(6'd16, 16'h0);
    wr(6'd8, 16'b0001); rd(6'd16, r); chk("R4 relocked", r, uniq(0, 0));
    wr(6'd0, 16'h8);

    // load sparse pattern masks
    for (int c = 0; c < NC; c++) begin
      for (int i = 0; i < NI; i++) mdl[c][i] = pat(c, i);
      wr(6'd8, 16'(1 << c));
      for (int s = 0; s < NS; s++) wr(6'(16 + s), mdl[c][s*16 +: 16]);
    end

    // R2/R7 single-bit sweep over every input
    for (int i = 0; i < NI; i++) begin
      v = '0; v[i] = 1'b1;
      strobe(v, "sweep");
    end
    strobe('0, "zero");
    strobe('1, "ones");
    for (int k = 0; k < 6; k++) begin
      v = '0;
      for (int i = 0; i < NI; i++) v[i] = ((i * (k + 3) + k) % 13) == 0;
      strobe(v, "mixed");
    end

    // R8 hold without strobe
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); trig_in = ~trig_in ^ NI'(k * 977);
    end
    @(negedge clk);
    chk("R8 hold chan_out", 16'(chan_out), 16'(exp_out));
    chk("R8 hold hist", hist_word, exp_hist);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule